// File: doc/BRIEF.md
# Instruction Trace Trigger Comparator

This block sits beside a core's retire stage and decides, for each retired instruction, whether it hits one programmed tracepoint. Every cycle it may receive an instruction strobe with the fetch address, the opcode, a flag that says whether the condition code let the instruction execute, the security state and the instruction size. It compares these against an address window, an opcode term, and condition, security and size qualifiers. It reports a registered match pulse. The selected trace action fires once, on the Nth qualifying hit.

Software or a debug agent sets it up through a write-only register port. The selector values are 0 low address, 1 high address, 2 opcode value, 3 opcode bound-or-mask, 4 control and 5 pass count. Selectors 6 and 7 are ignored. The control word packs, from bit 0 upward:
- the opcode mode in bits [1:0];
- the address invert in bit 2 and the opcode invert in bit 3;
- the condition mode in bits [5:4];
- the security enable in bit 6 and the security world in bit 7;
- the size mode in bits [9:8];
- the action in bits [12:10].

Top module: `itrace_trig_cmp`

## Requirements
- R1: While rst_ni is low and after its release, match_o and fire_o are 0 and action_o is 0, and the occurrence count is cleared.
- R2: When the action is Trace Instructions (3) or Trace Instructions and Data (4), the address term holds for low <= address <= high, with both bounds inclusive.
- R3: For actions Trigger (0), Start (1) and Stop (2), the address term holds only when the address equals the low address, and the high address is not used.
- R4: Opcode mode 0 ignores the opcode. Mode 1 needs opcode == value. Mode 2 needs value <= opcode <= bound.
- R5: Opcode mode 3 needs (opcode & mask) == (value & mask), where mask bits at 0 are don't-care. With mask 0xFFFF00FF and value 0xEA000040, any bits [15:8] are accepted.
- R6: Control bit 2 inverts the address term. Control bit 3 inverts the opcode term when the opcode mode is not 0.
- R7: Condition mode 1 accepts only instructions with cond_pass_i=1, mode 2 accepts only those with cond_pass_i=0, and modes 0 and 3 accept both.
- R8: With control bit 6 at 0 any security state matches. With it at 1, secure_i must equal control bit 7, where 1 means Secure.
- R9: Size mode 1 accepts only halfword (size_word_i=0), mode 2 only word (size_word_i=1), and modes 0 and 3 accept both.
- R10: match_o rises in the cycle after a valid instruction that meets every term, and it is never set after a cycle with instr_valid_i low.
- R11: With pass count N, fire_o pulses together with match_o on the Nth match, and N of 0 or 1 means the first match. After firing, no further fire occurs until a config write.
- R12: action_o carries the action code (0 to 4) while fire_o is 1 and is 0 otherwise. A written action code of 5 to 7 is stored as 0.
- R13: A config write to selectors 0 to 5 takes effect from the next cycle and clears the occurrence count. No fire follows a cycle containing a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 3 | Config register selector |
| cfg_wdata_i | input | 32 | Config write data |
| instr_valid_i | input | 1 | Retired-instruction strobe |
| instr_addr_i | input | ADDR_W | Instruction address |
| instr_op_i | input | DATA_W | Instruction opcode |
| cond_pass_i | input | 1 | Condition code passed (instruction executed) |
| secure_i | input | 1 | 1 = Secure state, 0 = Normal |
| size_word_i | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| match_o | output | 1 | Registered qualifying-match pulse |
| fire_o | output | 1 | Action fires on the Nth match |
| action_o | output | 3 | Action code while fire_o is high |

## Verification
The assertions assume that every input is at a known level from reset release onward. They also assume that config writes and instructions are sampled on the same clock edge, so the effect of a write lines up with the match pipeline. The stimulus changes inputs only at the falling edge, holds instr_valid_i low during config cycles, and drives only defined values. It still sends illegal action codes and unused selectors, to exercise the sanitising and ignore paths at the ports.

// File: rtl/itt_pkg.sv
package itt_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_OP_VAL  = 3'd2,
    SEL_OP_AUX  = 3'd3,
    SEL_CTRL    = 3'd4,
    SEL_PASS    = 3'd5
  } sel_e;

  localparam logic [2:0] ACT_TRIG     = 3'd0;
  localparam logic [2:0] ACT_START    = 3'd1;
  localparam logic [2:0] ACT_STOP     = 3'd2;
  localparam logic [2:0] ACT_TR_I     = 3'd3;
  localparam logic [2:0] ACT_TR_ID    = 3'd4;

  localparam logic [1:0] OPM_OFF   = 2'd0;
  localparam logic [1:0] OPM_EQ    = 2'd1;
  localparam logic [1:0] OPM_RANGE = 2'd2;
  localparam logic [1:0] OPM_MASK  = 2'd3;

  localparam logic [1:0] CCM_PASS = 2'd1;
  localparam logic [1:0] CCM_FAIL = 2'd2;

  localparam logic [1:0] SZM_HALF = 2'd1;
  localparam logic [1:0] SZM_WORD = 2'd2;

  typedef struct packed {
    logic [2:0] act;
    logic [1:0] size_m;
    logic       sec_world;
    logic       sec_en;
    logic [1:0] cc_m;
    logic       op_inv;
    logic       addr_inv;
    logic [1:0] op_m;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/itt_cfg_regs.sv
module itt_cfg_regs
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [ADDR_W-1:0] addr_lo_o,
  output logic [ADDR_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] op_val_o,
  output logic [DATA_W-1:0] op_aux_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  pass_n_o,
  output logic              wr_o
);
  ctrl_t ctrl_w;

  always_comb begin
    ctrl_w = ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (ctrl_w.act > ACT_TR_ID) ctrl_w.act = ACT_TRIG;  // illegal codes fold to trigger
  end

  assign wr_o = we_i && (sel_i <= SEL_PASS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_o <= '0;
      addr_hi_o <= '0;
      op_val_o  <= '0;
      op_aux_o  <= '0;
      ctrl_o    <= '0;
      pass_n_o  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_ADDR_LO: addr_lo_o <= wdata_i[ADDR_W-1:0];
        SEL_ADDR_HI: addr_hi_o <= wdata_i[ADDR_W-1:0];
        SEL_OP_VAL:  op_val_o  <= wdata_i[DATA_W-1:0];
        SEL_OP_AUX:  op_aux_o  <= wdata_i[DATA_W-1:0];
        SEL_CTRL:    ctrl_o    <= ctrl_w;
        SEL_PASS:    pass_n_o  <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/itt_match.sv
module itt_match
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              cond_pass_i,
  input  logic              secure_i,
  input  logic              size_word_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic [ADDR_W-1:0] addr_hi_i,
  input  logic [DATA_W-1:0] op_val_i,
  input  logic [DATA_W-1:0] op_aux_i,
  input  ctrl_t             ctrl_i,
  output logic              hit_o
);
  logic use_range, addr_raw, addr_ok;
  logic op_raw, op_ok, cc_ok, sec_ok, size_ok;

  // range compare only legal with the two trace-instruction actions
  assign use_range = (ctrl_i.act == ACT_TR_I) || (ctrl_i.act == ACT_TR_ID);
  assign addr_raw  = use_range ? ((addr_i >= addr_lo_i) && (addr_i <= addr_hi_i))
                               : (addr_i == addr_lo_i);
  assign addr_ok   = addr_raw ^ ctrl_i.addr_inv;

  always_comb begin
    unique case (ctrl_i.op_m)
      OPM_EQ:    op_raw = (op_i == op_val_i);
      OPM_RANGE: op_raw = (op_i >= op_val_i) && (op_i <= op_aux_i);
      OPM_MASK:  op_raw = ((op_i ^ op_val_i) & op_aux_i) == '0;
      default:   op_raw = 1'b1;
    endcase
  end
  assign op_ok = (ctrl_i.op_m == OPM_OFF) ? 1'b1 : (op_raw ^ ctrl_i.op_inv);

  always_comb begin
    unique case (ctrl_i.cc_m)
      CCM_PASS: cc_ok = cond_pass_i;
      CCM_FAIL: cc_ok = !cond_pass_i;
      default:  cc_ok = 1'b1;
    endcase
    unique case (ctrl_i.size_m)
      SZM_HALF: size_ok = !size_word_i;
      SZM_WORD: size_ok = size_word_i;
      default:  size_ok = 1'b1;
    endcase
  end

  assign sec_ok = !ctrl_i.sec_en || (secure_i == ctrl_i.sec_world);
  assign hit_o  = valid_i && addr_ok && op_ok && cc_ok && sec_ok && size_ok;
endmodule

// File: rtl/itt_pass_cnt.sv
module itt_pass_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] pass_n_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic             done_q;

  // N of 0 and 1 both mean the first occurrence
  assign last_idx = (pass_n_i == '0) ? '0 : pass_n_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (clr_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (hit_i && !done_q) begin
        if (cnt_q == last_idx) begin
          fire_o <= 1'b1;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/itrace_trig_cmp.sv
module itrace_trig_cmp
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              instr_valid_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  input  logic [DATA_W-1:0] instr_op_i,
  input  logic              cond_pass_i,
  input  logic              secure_i,
  input  logic              size_word_i,
  output logic              match_o,
  output logic              fire_o,
  output logic [2:0]        action_o
);
  logic [ADDR_W-1:0] addr_lo, addr_hi;
  logic [DATA_W-1:0] op_val, op_aux;
  logic [CNT_W-1:0]  pass_n;
  ctrl_t             ctrl;
  logic              cfg_wr, hit;
  logic [2:0]        act_q;

  itt_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .addr_lo_o(addr_lo),
    .addr_hi_o(addr_hi),
    .op_val_o (op_val),
    .op_aux_o (op_aux),
    .ctrl_o   (ctrl),
    .pass_n_o (pass_n),
    .wr_o     (cfg_wr)
  );

  itt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .valid_i    (instr_valid_i),
    .addr_i     (instr_addr_i),
    .op_i       (instr_op_i),
    .cond_pass_i,
    .secure_i,
    .size_word_i,
    .addr_lo_i  (addr_lo),
    .addr_hi_i  (addr_hi),
    .op_val_i   (op_val),
    .op_aux_i   (op_aux),
    .ctrl_i     (ctrl),
    .hit_o      (hit)
  );

  itt_pass_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .hit_i   (hit),
    .clr_i   (cfg_wr),
    .pass_n_i(pass_n),
    .fire_o  (fire_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      act_q   <= ACT_TRIG;
    end else begin
      match_o <= hit;
      if (hit) act_q <= ctrl.act;
    end
  end

  assign action_o = fire_o ? act_q : ACT_TRIG;
endmodule

// File: rtl/itrace_trig_cmp_chk.sv
module itrace_trig_cmp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       instr_valid_i,
  input logic       match_o,
  input logic       fire_o,
  input logic [2:0] action_o
);
  a_r10_idle_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> !match_o);
  a_r10_match_has_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(instr_valid_i));
  a_r11_fire_with_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> match_o);
  a_r11_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r12_action_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (action_o <= 3'd4));
  a_r12_action_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |-> (action_o == 3'd0));
  a_r13_write_blocks_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !fire_o);
endmodule

bind itrace_trig_cmp itrace_trig_cmp_chk u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .instr_valid_i, .match_o, .fire_o, .action_o
);

// File: tb/itrace_trig_cmp_test.sv
module itrace_trig_cmp_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_addr_i = '0;
  logic [31:0] instr_op_i = '0;
  logic        cond_pass_i = 1'b0;
  logic        secure_i = 1'b0;
  logic        size_word_i = 1'b0;
  logic        match_o, fire_o;
  logic [2:0]  action_o;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  typedef struct {
    bit       m;
    bit       f;
    bit [2:0] a;
    string    tag;
  } exp_t;
  exp_t q[$];

  // bench-side configuration model
  bit [31:0] m_lo, m_hi, m_val, m_aux, m_n, m_cnt;
  bit [2:0]  m_act;
  bit [1:0]  m_opm, m_cc, m_sz;
  bit        m_ainv, m_oinv, m_sen, m_sw, m_done;

  always #4 clk_i = ~clk_i;

  itrace_trig_cmp uut (.*);

  function automatic bit [31:0] ctl(bit [2:0] act, bit [1:0] sz, bit sw, bit sen,
                                    bit [1:0] cc, bit oinv, bit ainv, bit [1:0] opm);
    return {19'd0, act, sz, sw, sen, cc, oinv, ainv, opm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit [2:0] sel, bit [31:0] d);
    exp_t e;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    case (sel)
      3'd0: m_lo = d;
      3'd1: m_hi = d;
      3'd2: m_val = d;
      3'd3: m_aux = d;
      3'd4: begin
        m_opm = d[1:0]; m_ainv = d[2]; m_oinv = d[3]; m_cc = d[5:4];
        m_sen = d[6]; m_sw = d[7]; m_sz = d[9:8];
        m_act = (d[12:10] > 3'd4) ? 3'd0 : d[12:10];
      end
      3'd5: m_n = d;
      default: ;
    endcase
    if (sel <= 3'd5) begin m_cnt = 0; m_done = 0; end
    e.m = 0; e.f = 0; e.a = 0; e.tag = "R13";
    q.push_back(e);
  endtask

  task automatic ins(string tag, bit v, bit [31:0] a, bit [31:0] op,
                     bit cp = 1, bit sec = 0, bit w = 1);
    exp_t e;
    bit ao, oo, cco, so, zo, hit, rng;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    instr_valid_i = v; instr_addr_i = a; instr_op_i = op;
    cond_pass_i = cp; secure_i = sec; size_word_i = w;
    rng = (m_act == 3'd3) || (m_act == 3'd4);
    ao = (rng ? (a >= m_lo && a <= m_hi) : (a == m_lo)) ^ m_ainv;
    case (m_opm)
      2'd1: oo = (op == m_val);
      2'd2: oo = (op >= m_val) && (op <= m_aux);
      2'd3: oo = ((op & m_aux) == (m_val & m_aux));
      default: oo = 1;
    endcase
    if (m_opm != 0) oo = oo ^ m_oinv;
    cco = (m_cc == 2'd1) ? cp : (m_cc == 2'd2) ? !cp : 1'b1;
    zo  = (m_sz == 2'd1) ? !w : (m_sz == 2'd2) ? w : 1'b1;
    so  = !m_sen || (sec == m_sw);
    hit = v && ao && oo && cco && zo && so;
    e.m = hit; e.f = 0; e.a = 0; e.tag = tag;
    if (hit && !m_done) begin
      m_cnt++;
      if (m_cnt >= ((m_n == 0) ? 1 : m_n)) begin
        e.f = 1; e.a = m_act; m_done = 1;
      end
    end
    q.push_back(e);
  endtask

  // monitor: one expected item per cycle, sampled after the edge settles
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " match"}, match_o, e.m);
      chk({e.tag, " fire"}, fire_o, e.f);
      chk({e.tag, " action"}, action_o, e.a);
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 match", match_o, 0);
    chk("R1 fire", fire_o, 0);
    chk("R1 action", action_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-release", {match_o, fire_o, action_o}, 0);

    // R2 inclusive window with trace-instr action; R10 valid low
    wr(0, 32'h1000); wr(1, 32'h1200); wr(5, 0);
    wr(4, ctl(3'd3, 0, 0, 0, 0, 0, 0, 0));
    ins("R2", 1, 32'h0FFF, 0);
    ins("R2", 1, 32'h1000, 0);
    ins("R2", 1, 32'h1200, 0);
    ins("R2", 1, 32'h1201, 0);
    ins("R10", 0, 32'h1100, 0);
    ins("R2", 1, 32'h1100, 0);

    // R3 exact address for trigger/start/stop; R12 action codes
    wr(4, ctl(3'd0, 0, 0, 0, 0, 0, 0, 0));
    ins("R3", 1, 32'h1100, 0);
    ins("R3", 1, 32'h1000, 0);
    wr(4, ctl(3'd1, 0, 0, 0, 0, 0, 0, 0));
    ins("R12", 1, 32'h1000, 0);
    wr(4, ctl(3'd2, 0, 0, 0, 0, 0, 0, 0));
    ins("R12", 1, 32'h1000, 0);
    wr(4, ctl(3'd4, 0, 0, 0, 0, 0, 0, 0));
    ins("R12", 1, 32'h11FF, 0);
    wr(4, ctl(3'd7, 0, 0, 0, 0, 0, 0, 0));
    ins("R12", 1, 32'h1000, 0);
    ins("R12", 1, 32'h1001, 0);

    // R4 opcode equal and range
    wr(2, 32'hEA000040); wr(3, 32'hEA00004F);
    wr(4, ctl(3'd3, 0, 0, 0, 0, 0, 0, 2'd1));
    ins("R4", 1, 32'h1100, 32'hEA000040);
    ins("R4", 1, 32'h1100, 32'hEA000041);
    wr(4, ctl(3'd3, 0, 0, 0, 0, 0, 0, 2'd2));
    ins("R4", 1, 32'h1100, 32'hEA00004F);
    ins("R4", 1, 32'h1100, 32'hEA000050);
    ins("R4", 1, 32'h1100, 32'hEA00003F);
    ins("R4", 1, 32'h1100, 32'hEA000040);

    // R5 mask mode
    wr(3, 32'hFFFF00FF);
    wr(4, ctl(3'd3, 0, 0, 0, 0, 0, 0, 2'd3));
    ins("R5", 1, 32'h1100, 32'hEA00AB40);
    ins("R5", 1, 32'h1100, 32'hEA00AB41);
    ins("R5", 1, 32'h1100, 32'hEB000040);

    // R6 inversion
    wr(4, ctl(3'd3, 0, 0, 0, 0, 0, 1, 0));
    ins("R6", 1, 32'h1100, 0);
    ins("R6", 1, 32'h2000, 0);
    wr(4, ctl(3'd3, 0, 0, 0, 0, 1, 0, 2'd3));
    ins("R6", 1, 32'h1100, 32'hEA00AB40);
    ins("R6", 1, 32'h1100, 32'h00000000);

    // R7 condition code
    wr(4, ctl(3'd3, 0, 0, 0, 2'd1, 0, 0, 0));
    ins("R7", 1, 32'h1100, 0, 0);
    ins("R7", 1, 32'h1100, 0, 1);
    wr(4, ctl(3'd3, 0, 0, 0, 2'd2, 0, 0, 0));
    ins("R7", 1, 32'h1100, 0, 1);
    ins("R7", 1, 32'h1100, 0, 0);

    // R8 security
    wr(4, ctl(3'd3, 0, 1, 1, 0, 0, 0, 0));
    ins("R8", 1, 32'h1100, 0, 1, 0);
    ins("R8", 1, 32'h1100, 0, 1, 1);
    wr(4, ctl(3'd3, 0, 0, 1, 0, 0, 0, 0));
    ins("R8", 1, 32'h1100, 0, 1, 1);
    ins("R8", 1, 32'h1100, 0, 1, 0);
    wr(4, ctl(3'd3, 0, 1, 0, 0, 0, 0, 0));
    ins("R8", 1, 32'h1100, 0, 1, 0);

    // R9 size
    wr(4, ctl(3'd3, 2'd1, 0, 0, 0, 0, 0, 0));
    ins("R9", 1, 32'h1100, 0, 1, 0, 1);
    ins("R9", 1, 32'h1100, 0, 1, 0, 0);
    wr(4, ctl(3'd3, 2'd2, 0, 0, 0, 0, 0, 0));
    ins("R9", 1, 32'h1100, 0, 1, 0, 0);
    ins("R9", 1, 32'h1100, 0, 1, 0, 1);

    // R11 Nth occurrence, hold, restart on write; R13 unused selector ignored
    wr(4, ctl(3'd4, 0, 0, 0, 0, 0, 0, 0));
    wr(5, 5);
    for (int i = 0; i < 7; i++) begin
      ins("R11", 1, 32'h1100, 0);
      ins("R11", 1, 32'h3000, 0);
    end
    wr(3'd6, 32'hFFFF_FFFF);
    ins("R13", 1, 32'h1100, 0);
    wr(5, 1);
    ins("R11", 1, 32'h1100, 0);
    ins("R11", 1, 32'h1100, 0);
    wr(5, 2);
    ins("R11", 0, 32'h1100, 0);
    ins("R11", 1, 32'h1100, 0);
    ins("R11", 1, 32'h1100, 0);

    @(negedge clk_i);
    instr_valid_i = 1'b0;
    cfg_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule